// File: doc/BRIEF.md
# Mailbox Transmit Priority Arbiter

This block holds the transmit-side state of a 32-mailbox message controller and decides which mailbox goes out next on a shared serial bus. Software programs it through a simple word-addressed register port. It enables mailboxes, sets each one's direction, raises send requests, withdraws requests, and clears acknowledge flags. Each mailbox also owns a 32-bit control word, which holds a 6-bit send priority, a length code and a remote-request flag.

When the external frame engine signals that the bus is free and no frame is in flight, the arbiter considers the registered request state. Of every mailbox that is enabled, set to transmit and pending, it picks the one with the largest priority value. Equal priorities go to the higher mailbox index. The grant is held until the frame engine reports completion. At that point the request is retired, the acknowledge flag is set and, if the mailbox is unmasked, a global interrupt flag is raised.

Top module: `mbox_tx_arb`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `grant_valid` is low and `irq` is low.
- R2: Writing the request register (word 2) sets the pending bit of each mailbox whose data bit is 1; 0 bits leave pending unchanged. Reading word 2 returns the pending bits.
- R3: Only mailboxes that are enabled (word 0 bit = 1), set to transmit (word 1 bit = 0) and pending take part. When none qualifies, a free-bus pulse leaves `grant_valid` low.
- R4: Among qualifying mailboxes, the one with the largest priority value in control-word bits 13:8 is granted. Control word n sits at word address 32+n.
- R5: When qualifying mailboxes share the top priority value, the highest mailbox index is granted.
- R6: A grant is taken only on the clock edge where `bus_free` is high and no frame is in flight. It appears on the next cycle and stays unchanged until `tx_done`. A request written in the same cycle as `bus_free`, or while a frame is in flight, waits for a later free-bus pulse.
- R7: `tx_done` while a grant is held clears that mailbox's pending bit and sets its acknowledge bit (word 4) on the same edge, and drops `grant_valid`. `tx_done` with no grant has no effect.
- R8: Writing 1 to a bit of word 4 clears that acknowledge bit; 0 bits have no effect.
- R9: The global interrupt flag (word 7 bit 0, driven on `irq`) sets when an acknowledge occurs for a mailbox whose mask bit (word 6) is 1. Writing 1 to word 7 bit 0 clears the flag.
- R10: Writing 1 to a bit of the abort register (word 3) withdraws a pending request that is not in flight and sets that mailbox's abort-acknowledge bit (word 5, write 1 to clear). A request that is in flight is not touched.
- R11: While `grant_valid` is high, `grant_len` shows bits 3:0 and `grant_rtr` shows bit 4 of the granted mailbox's control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| bus_free | input | 1 | Frame engine reports the bus idle |
| tx_done | input | 1 | Frame engine reports the granted frame sent |
| grant_valid | output | 1 | A mailbox is granted and in flight |
| grant_idx | output | 5 | Index of the granted mailbox |
| grant_len | output | 4 | Length code of the granted mailbox |
| grant_rtr | output | 1 | Remote-request flag of the granted mailbox |
| irq | output | 1 | Global mailbox interrupt flag |

## Verification
The hardest situation to reach is a change of request state while a frame is in flight. This covers a higher-priority request arriving, a second free-bus pulse and an abort aimed at the granted mailbox. Each must leave the current grant intact and still be honoured at the next arbitration. The stimulus reaches it by granting a low-priority mailbox, then writing a stronger request, pulsing `bus_free` and aborting the granted index before issuing `tx_done`. A vector table varies enable, direction, pending and priority patterns to cover ties and exclusions.

// File: rtl/mbox_arb_pkg.sv
// Package: register word map and control-word field positions shared by the
// mailbox transmit arbiter and its checker.
package mbox_arb_pkg;

    // Global register selects (word address when the top address bit is 0).
    typedef enum logic [2:0] {
        SEL_ENA    = 3'd0,
        SEL_DIR    = 3'd1,
        SEL_REQ    = 3'd2,
        SEL_ABORT  = 3'd3,
        SEL_ACK    = 3'd4,
        SEL_ABACK  = 3'd5,
        SEL_IMASK  = 3'd6,
        SEL_GFLAG  = 3'd7
    } reg_sel_e;

    // Control-word field positions.
    localparam int unsigned PRIO_LSB = 8;
    localparam int unsigned PRIO_W   = 6;
    localparam int unsigned LEN_LSB  = 0;
    localparam int unsigned LEN_W    = 4;
    localparam int unsigned RTR_BIT  = 4;

endpackage

// File: rtl/mbox_regs.sv
// Module: mbox_regs
// Holds the mailbox register state. It covers enable, direction, pending,
// acknowledge, abort-acknowledge, interrupt mask, global flag and one
// control word per mailbox. It applies software writes and frame-engine
// completions.
// Assumes NUM_MBOX <= DATA_W and ADDR_W == IDX_W + 1. The upper half of
// the address space holds the control words.
module mbox_regs
    import mbox_arb_pkg::*;
#(
    parameter int unsigned NUM_MBOX = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_MBOX),
    parameter int unsigned ADDR_W   = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                done_fire,
    input  logic [IDX_W-1:0]    done_idx,
    input  logic                busy,
    input  logic [IDX_W-1:0]    busy_idx,
    output logic [NUM_MBOX-1:0] ena_o,
    output logic [NUM_MBOX-1:0] dir_o,
    output logic [NUM_MBOX-1:0] pend_o,
    output logic [NUM_MBOX-1:0] ack_o,
    output logic [DATA_W-1:0]   ctrl_o [NUM_MBOX],
    output logic                irq_o
);

    localparam logic [NUM_MBOX-1:0] ONE_HOT0 = NUM_MBOX'(1);

    logic [NUM_MBOX-1:0] ena_q, dir_q, pend_q, ack_q, abak_q, imask_q;
    logic                gflag_q;
    logic [DATA_W-1:0]   ctrl_q [NUM_MBOX];

    logic                glob_wr;
    logic                ctrl_wr;
    reg_sel_e            wsel;
    logic [NUM_MBOX-1:0] wbits;
    logic [NUM_MBOX-1:0] done_vec;
    logic [NUM_MBOX-1:0] flight_vec;
    logic [NUM_MBOX-1:0] set_vec;
    logic [NUM_MBOX-1:0] abort_vec;
    logic [NUM_MBOX-1:0] ack_clr;
    logic [NUM_MBOX-1:0] abak_clr;

    // Decode the write strobe into per-register bit vectors.
    always_comb begin
        glob_wr    = wr_en && !wr_addr[ADDR_W-1];
        ctrl_wr    = wr_en &&  wr_addr[ADDR_W-1];
        wsel       = reg_sel_e'(wr_addr[2:0]);
        wbits      = wr_data[NUM_MBOX-1:0];
        done_vec   = done_fire ? (ONE_HOT0 << done_idx) : '0;
        flight_vec = busy ? (ONE_HOT0 << busy_idx) : '0;
        set_vec    = (glob_wr && wsel == SEL_REQ)   ? wbits : '0;
        abort_vec  = (glob_wr && wsel == SEL_ABORT) ? (wbits & pend_q & ~flight_vec) : '0;
        ack_clr    = (glob_wr && wsel == SEL_ACK)   ? wbits : '0;
        abak_clr   = (glob_wr && wsel == SEL_ABACK) ? wbits : '0;
    end

    // Plain read/write configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q   <= '0;
            dir_q   <= '0;
            imask_q <= '0;
        end else if (glob_wr) begin
            if (wsel == SEL_ENA)   ena_q   <= wbits;
            if (wsel == SEL_DIR)   dir_q   <= wbits;
            if (wsel == SEL_IMASK) imask_q <= wbits;
        end
    end

    // Pending requests: set by software, retired by completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~done_vec & ~abort_vec) | set_vec;
    end

    // Acknowledge and abort-acknowledge flags: hardware set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= '0;
            abak_q <= '0;
        end else begin
            ack_q  <= (ack_q  & ~ack_clr)  | done_vec;
            abak_q <= (abak_q & ~abak_clr) | abort_vec;
        end
    end

    // Global mailbox interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gflag_q <= 1'b0;
        else if (done_fire && imask_q[done_idx])
            gflag_q <= 1'b1;
        else if (glob_wr && wsel == SEL_GFLAG && wr_data[0])
            gflag_q <= 1'b0;
    end

    // One control word per mailbox.
    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_ctrl
        // Write control word m when its address is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[m] <= '0;
            else if (ctrl_wr && wr_addr[IDX_W-1:0] == IDX_W'(m))
                ctrl_q[m] <= wr_data;
        end
        assign ctrl_o[m] = ctrl_q[m];
    end

    // Combinational read multiplexer.
    always_comb begin
        rd_data = '0;
        if (rd_addr[ADDR_W-1]) begin
            rd_data = ctrl_q[rd_addr[IDX_W-1:0]];
        end else begin
            case (reg_sel_e'(rd_addr[2:0]))
                SEL_ENA:   rd_data[NUM_MBOX-1:0] = ena_q;
                SEL_DIR:   rd_data[NUM_MBOX-1:0] = dir_q;
                SEL_REQ:   rd_data[NUM_MBOX-1:0] = pend_q;
                SEL_ABORT: rd_data = '0;
                SEL_ACK:   rd_data[NUM_MBOX-1:0] = ack_q;
                SEL_ABACK: rd_data[NUM_MBOX-1:0] = abak_q;
                SEL_IMASK: rd_data[NUM_MBOX-1:0] = imask_q;
                SEL_GFLAG: rd_data[0] = gflag_q;
                default:   rd_data = '0;
            endcase
        end
    end

    assign ena_o  = ena_q;
    assign dir_o  = dir_q;
    assign pend_o = pend_q;
    assign ack_o  = ack_q;
    assign irq_o  = gflag_q;

endmodule

// File: rtl/mbox_prio_pick.sv
// Module: mbox_prio_pick
// Combinational selector. It forms a key {priority, index} for every
// qualifying mailbox and returns the largest key. This yields the highest
// priority, with ties going to the higher index.
// Assumes NUM_MBOX keys are distinct because the index is part of the key.
module mbox_prio_pick
    import mbox_arb_pkg::*;
#(
    parameter int unsigned NUM_MBOX = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_MBOX)
) (
    input  logic [NUM_MBOX-1:0] ena,
    input  logic [NUM_MBOX-1:0] dir,
    input  logic [NUM_MBOX-1:0] pend,
    input  logic [DATA_W-1:0]   ctrl [NUM_MBOX],
    output logic                pick_valid,
    output logic [IDX_W-1:0]    pick_idx
);

    localparam int unsigned KEY_W = PRIO_W + IDX_W;

    logic [NUM_MBOX-1:0] qual;
    logic [KEY_W-1:0]    key [NUM_MBOX];

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_key
        assign qual[m] = ena[m] && !dir[m] && pend[m];
        assign key[m]  = {ctrl[m][PRIO_LSB +: PRIO_W], IDX_W'(m)};
    end

    logic [KEY_W-1:0] best;

    // Scan all keys and keep the largest qualifying one.
    always_comb begin
        pick_valid = 1'b0;
        best       = '0;
        for (int m = 0; m < NUM_MBOX; m++) begin
            if (qual[m] && (!pick_valid || key[m] > best)) begin
                pick_valid = 1'b1;
                best       = key[m];
            end
        end
        pick_idx = best[IDX_W-1:0];
    end

endmodule

// File: rtl/mbox_grant_ctl.sv
// Module: mbox_grant_ctl
// Grant state machine. It latches the selected mailbox on a free-bus pulse
// while idle, holds it until completion, and reports the completion edge.
// Assumes tx_done is meaningful only while a grant is held.
module mbox_grant_ctl #(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_free,
    input  logic             tx_done,
    input  logic             pick_valid,
    input  logic [IDX_W-1:0] pick_idx,
    output logic             busy_o,
    output logic [IDX_W-1:0] grant_idx_o,
    output logic             done_fire_o
);

    typedef enum logic {ST_IDLE = 1'b0, ST_FLIGHT = 1'b1} gst_e;

    gst_e             st_q;
    logic [IDX_W-1:0] idx_q;

    // Move between idle and in-flight; capture the winner on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (bus_free && pick_valid) begin
                    st_q  <= ST_FLIGHT;
                    idx_q <= pick_idx;
                end
                ST_FLIGHT: if (tx_done) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (st_q == ST_FLIGHT);
    assign grant_idx_o = idx_q;
    assign done_fire_o = (st_q == ST_FLIGHT) && tx_done;

endmodule

// File: rtl/mbox_tx_arb.sv
// Module: mbox_tx_arb (top)
// Mailbox transmit priority arbiter. It joins the register file, the
// priority selector and the grant controller, and presents the granted
// mailbox's length code and remote-request flag.
// Assumes a single frame engine that pulses bus_free and tx_done.
module mbox_tx_arb
    import mbox_arb_pkg::*;
#(
    parameter int unsigned NUM_MBOX = 32,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned IDX_W    = $clog2(NUM_MBOX),
    parameter int unsigned ADDR_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bus_free,
    input  logic              tx_done,
    output logic              grant_valid,
    output logic [IDX_W-1:0]  grant_idx,
    output logic [LEN_W-1:0]  grant_len,
    output logic              grant_rtr,
    output logic              irq
);

    logic [NUM_MBOX-1:0] ena_q, dir_q, pend_q, ack_q;
    logic [DATA_W-1:0]   ctrl_q [NUM_MBOX];
    logic                busy;
    logic [IDX_W-1:0]    busy_idx;
    logic                done_fire;
    logic                pick_valid;
    logic [IDX_W-1:0]    pick_idx;

    mbox_regs #(
        .NUM_MBOX(NUM_MBOX), .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .done_fire(done_fire), .done_idx(busy_idx),
        .busy(busy), .busy_idx(busy_idx),
        .ena_o(ena_q), .dir_o(dir_q), .pend_o(pend_q), .ack_o(ack_q),
        .ctrl_o(ctrl_q), .irq_o(irq)
    );

    mbox_prio_pick #(
        .NUM_MBOX(NUM_MBOX), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) pick_i (
        .ena(ena_q), .dir(dir_q), .pend(pend_q), .ctrl(ctrl_q),
        .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    mbox_grant_ctl #(
        .IDX_W(IDX_W)
    ) gctl_i (
        .clk(clk), .rst_n(rst_n),
        .bus_free(bus_free), .tx_done(tx_done),
        .pick_valid(pick_valid), .pick_idx(pick_idx),
        .busy_o(busy), .grant_idx_o(busy_idx), .done_fire_o(done_fire)
    );

    // Present the grant and the granted mailbox's frame attributes.
    always_comb begin
        grant_valid = busy;
        grant_idx   = busy_idx;
        grant_len   = busy ? ctrl_q[busy_idx][LEN_LSB +: LEN_W] : '0;
        grant_rtr   = busy ? ctrl_q[busy_idx][RTR_BIT] : 1'b0;
    end

endmodule

// File: rtl/mbox_tx_arb_chk.sv
// Module: mbox_tx_arb_chk
// Checker for the mailbox transmit arbiter, attached through bind. It
// relates the grant, completion, request and interrupt behaviour over time.
module mbox_tx_arb_chk #(
    parameter int unsigned NUM_MBOX = 32,
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned ADDR_W   = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                bus_free,
    input logic                tx_done,
    input logic                grant_valid,
    input logic [IDX_W-1:0]    grant_idx,
    input logic                irq,
    input logic [NUM_MBOX-1:0] ena_vec,
    input logic [NUM_MBOX-1:0] dir_vec,
    input logic [NUM_MBOX-1:0] pend_vec,
    input logic [NUM_MBOX-1:0] ack_vec
);

    localparam logic [ADDR_W-1:0] REQ_ADDR = ADDR_W'(2);

    logic [NUM_MBOX-1:0] qual_q;

    // Remember last cycle's qualifying set to judge a new grant.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= ena_vec & ~dir_vec & pend_vec;
    end

    // R6: a held grant keeps its index until completion.
    a_r6_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !tx_done |=> grant_valid && $stable(grant_idx));

    // R6: a new grant needs a free-bus pulse on the previous edge.
    a_r6_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> $past(bus_free));

    // R3: a new grant names a mailbox that qualified.
    a_r3_grant_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> qual_q[grant_idx]);

    // R7: completion drops the grant.
    a_r7_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && tx_done |=> !grant_valid);

    // R7: completion sets ack and clears pending on the same edge.
    a_r7_ack_and_retire: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && tx_done && !(wr_en && wr_addr == REQ_ADDR)
        |=> ack_vec[$past(grant_idx)] && !pend_vec[$past(grant_idx)]);

    // R9: the interrupt flag only rises from a completion.
    a_r9_irq_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(grant_valid && tx_done));

endmodule

bind mbox_tx_arb mbox_tx_arb_chk #(
    .NUM_MBOX(NUM_MBOX), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .bus_free(bus_free), .tx_done(tx_done),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .irq(irq),
    .ena_vec(ena_q), .dir_vec(dir_q), .pend_vec(pend_q), .ack_vec(ack_q)
);

// File: tb/mbox_tx_arb_tb_top.sv
`timescale 1ns/1ps
module mbox_tx_arb_tb_top;

    localparam logic [5:0] A_ENA = 6'd0, A_DIR = 6'd1, A_REQ = 6'd2, A_ABORT = 6'd3,
                           A_ACK = 6'd4, A_ABACK = 6'd5, A_IMASK = 6'd6, A_GFLAG = 6'd7,
                           A_CTRL = 6'd32;

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] dir;
        logic [31:0] req;
        logic [4:0]  a;
        logic [5:0]  pa;
        logic [4:0]  b;
        logic [5:0]  pb;
        logic        v;
        logic [4:0]  idx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'hFFFF_FFFF, 32'h0, 32'h0,         5'd1,  6'd0,  5'd2,  6'd0,  1'b0, 5'd0},
        '{32'hFFFF_FFFF, 32'h0, 32'h0000_00F0, 5'd5,  6'd10, 5'd6,  6'd9,  1'b1, 5'd5},
        '{32'hFFFF_FFFF, 32'h0, 32'h0000_0F00, 5'd9,  6'd20, 5'd11, 6'd20, 1'b1, 5'd11},
        '{32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 5'd1,  6'd0,  5'd2,  6'd0,  1'b1, 5'd31},
        '{32'hFFFF_FFFF, 32'h0, 32'h8000_0001, 5'd0,  6'd63, 5'd31, 6'd62, 1'b1, 5'd0},
        '{32'h7FFF_FFFF, 32'h0, 32'h8000_0001, 5'd31, 6'd63, 5'd1,  6'd0,  1'b1, 5'd0},
        '{32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0001, 5'd31, 6'd63, 5'd1, 6'd0, 1'b1, 5'd0},
        '{32'h0,         32'h0, 32'hFFFF_FFFF, 5'd1,  6'd0,  5'd2,  6'd0,  1'b0, 5'd0},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd1, 6'd0, 5'd2, 6'd0, 1'b0, 5'd0},
        '{32'hFFFF_FFFF, 32'h0, 32'h0010_0000, 5'd20, 6'd1,  5'd3,  6'd63, 1'b1, 5'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        bus_free = 1'b0;
    logic        tx_done = 1'b0;
    logic        grant_valid;
    logic [4:0]  grant_idx;
    logic [3:0]  grant_len;
    logic        grant_rtr;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    mbox_tx_arb dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bus_free(bus_free), .tx_done(tx_done),
        .grant_valid(grant_valid), .grant_idx(grant_idx), .grant_len(grant_len),
        .grant_rtr(grant_rtr), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic free_pulse();
        @(negedge clk); bus_free = 1'b1;
        @(negedge clk); bus_free = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic clean();
        if (grant_valid) done_pulse();
        wr(A_ABORT, 32'hFFFF_FFFF);
        wr(A_ACK, 32'hFFFF_FFFF);
        wr(A_ABACK, 32'hFFFF_FFFF);
        wr(A_GFLAG, 32'h1);
        for (int m = 0; m < 32; m++) wr(A_CTRL + 6'(m), 32'h0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 grant_valid", 32'(grant_valid), 0);
        chk("R1 irq", 32'(irq), 0);
        for (int a = 0; a < 8; a++) begin
            rd(6'(a), d); chk("R1 reg", d, 0);
        end
        rd(A_CTRL + 6'd17, d); chk("R1 ctrl", d, 0);

        // R2 request set semantics
        wr(A_REQ, 32'h0); rd(A_REQ, d); chk("R2 zero write", d, 0);
        wr(A_REQ, 32'h5); rd(A_REQ, d); chk("R2 set", d, 32'h5);
        wr(A_REQ, 32'h0); rd(A_REQ, d); chk("R2 zero keeps", d, 32'h5);
        wr(A_REQ, 32'h8); rd(A_REQ, d); chk("R2 accumulate", d, 32'hD);
        clean();

        // R3 R4 R5 vector table
        for (int v = 0; v < NV; v++) begin
            wr(A_ENA, VECS[v].en);
            wr(A_DIR, VECS[v].dir);
            wr(A_CTRL + {1'b0, VECS[v].a}, {18'h0, VECS[v].pa, 8'h0});
            wr(A_CTRL + {1'b0, VECS[v].b}, {18'h0, VECS[v].pb, 8'h0});
            wr(A_REQ, VECS[v].req);
            free_pulse();
            chk("R3/R4/R5 table valid", 32'(grant_valid), 32'(VECS[v].v));
            if (VECS[v].v) begin
                chk("R4/R5 table idx", 32'(grant_idx), 32'(VECS[v].idx));
                done_pulse();
                rd(A_ACK, d); chk("R7 table ack", d, 32'h1 << VECS[v].idx);
            end
            clean();
        end
        wr(A_DIR, 32'h0);
        wr(A_ENA, 32'hFFFF_FFFF);

        // R6 request written on the bus_free edge waits
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_REQ; wr_data = 32'h200; bus_free = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; bus_free = 1'b0;
        chk("R6 same-edge request", 32'(grant_valid), 0);
        free_pulse();
        chk("R6 later grant", 32'(grant_idx), 9);
        chk("R6 later grant valid", 32'(grant_valid), 1);
        clean();

        // R11 attributes, R6 hold during flight, R10 in-flight abort ignored
        wr(A_CTRL + 6'd4, (32'd5 << 8) | (32'd1 << 4) | 32'd3);
        wr(A_REQ, 32'h10);
        free_pulse();
        chk("R11 idx", 32'(grant_idx), 4);
        chk("R11 len", 32'(grant_len), 3);
        chk("R11 rtr", 32'(grant_rtr), 1);
        wr(A_CTRL + 6'd7, 32'd40 << 8);
        wr(A_REQ, 32'h80);
        free_pulse();
        chk("R6 hold idx", 32'(grant_idx), 4);
        chk("R6 hold valid", 32'(grant_valid), 1);
        wr(A_ABORT, 32'h10);
        rd(A_REQ, d); chk("R10 in-flight kept", d, 32'h90);
        rd(A_ABACK, d); chk("R10 no abort ack", d, 0);
        done_pulse();
        chk("R7 grant drops", 32'(grant_valid), 0);
        rd(A_ACK, d); chk("R7 ack set", d, 32'h10);
        rd(A_REQ, d); chk("R7 pending cleared", d, 32'h80);
        chk("R9 masked-off no irq", 32'(irq), 0);
        free_pulse();
        chk("R6 next arbitration", 32'(grant_idx), 7);
        wr(A_IMASK, 32'h80);
        done_pulse();
        chk("R9 irq set", 32'(irq), 1);
        wr(A_GFLAG, 32'h0);
        chk("R9 zero write keeps", 32'(irq), 1);
        wr(A_GFLAG, 32'h1);
        chk("R9 irq cleared", 32'(irq), 0);

        // R8 acknowledge clearing
        wr(A_ACK, 32'h0); rd(A_ACK, d); chk("R8 zero write", d, 32'h90);
        wr(A_ACK, 32'h10); rd(A_ACK, d); chk("R8 w1c", d, 32'h80);

        // R7 tx_done with no grant is ignored
        done_pulse();
        rd(A_ACK, d); chk("R7 idle done", d, 32'h80);
        chk("R7 idle done irq", 32'(irq), 0);

        // R10 abort of a waiting request
        wr(A_REQ, 32'h4);
        wr(A_ABORT, 32'h4);
        rd(A_REQ, d); chk("R10 withdrawn", d, 0);
        rd(A_ABACK, d); chk("R10 abort ack", d, 32'h4);
        free_pulse();
        chk("R10 nothing granted", 32'(grant_valid), 0);
        wr(A_ABACK, 32'h4); rd(A_ABACK, d); chk("R10 abort ack clear", d, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule